// File: doc/BRIEF.md
# Serial CRC Generator and Checker

This block computes an n-bit cyclic redundancy check over a bit stream, taking one message bit per clock. The generator polynomial, the register width, the starting register value, the pattern XORed into the result, output bit reflection, output byte reversal and the expected check residue are all elaboration parameters. A start strobe opens a message and an end strobe closes it. The formatted check value appears on `crc_o` in the cycle after the end strobe and stays there until the next start.

The division is done without appending zero bits. Each arriving bit is combined with the bit leaving the top of the remainder register, and the result decides whether the polynomial is folded back in. When a message is opened with `check_i` high, the block treats the stream as a whole codeword, with the message followed by its check value. At the end it compares the raw remainder against the configured residue and reports the outcome on `pass_o`. For links that send each byte least-significant bit first, the bits are fed in wire order and reflection is enabled, so that the register contents are bit-reversed before the output XOR.

Top module: `crc_serial_engine`

## Requirements
- R1: With POLY listing the coefficients below x^n (the x^n term is implied), the raw remainder after a message M of L bits is (INIT·x^L + M·x^n) mod G. For POLY=3'b011 (x^3+x+1) with zero INIT, the 14-bit message 11010011101100 gives crc_o = 3'b100.
- R2: Wide generators are supported. Width 16 with POLY 0x1021 and INIT 0xFFFF, over the ASCII bytes "123456789" sent MSB first, gives raw remainder 0x29B1. Width 32 with POLY 0x04C11DB7, INIT and XOR_OUT all ones and reflection on, over the same bytes sent LSB first, gives crc_o = 0xCBF43926.
- R3: start_i loads INIT into the remainder register. With a non-zero INIT, one leading zero bit and two leading zero bits give different results. With a zero INIT, leading zero bits do not change the result.
- R4: The output is formed in this order. First the raw remainder is bit-reversed across all WIDTH bits when REFLECT=1. Then it is XORed with XOR_OUT. Then, when BYTE_SWAP=1 and WIDTH is a multiple of 8, its bytes are put in reverse order, so that byte k moves to byte WIDTH/8-1-k.
- R5: check_i is sampled with start_i. In check mode, pass_o is 1 in the cycle after the end strobe exactly when the raw remainder equals RESIDUE. A correct codeword passes and a codeword with one flipped bit fails. In generate mode pass_o stays 0.
- R6: start_i has priority over bit_valid_i and end_i in the same cycle. The bit offered in that cycle is dropped, and a start in the middle of a message discards the bits already taken.
- R7: Cycles with bit_valid_i low leave the remainder unchanged, so gaps do not change the result. A valid bit in the same cycle as end_i is part of the message.
- R8: One cycle after end_i, done_o is 1. crc_o, pass_o and done_o then hold until the next start, which drops done_o and pass_o. Bits and end strobes that arrive while no message is open are ignored.
- R9: After reset, done_o, pass_o and crc_o are all 0.
- R10: A message with no bits (start followed directly by end) yields the formatted INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a message and loads the initial value |
| check_i | input | 1 | Selects check mode for the message opened with start_i |
| bit_valid_i | input | 1 | Marks bit_i as a message bit this cycle |
| bit_i | input | 1 | Message bit, in wire order |
| end_i | input | 1 | Closes the message |
| crc_o | output | WIDTH | Formatted check value |
| done_o | output | 1 | Result valid |
| pass_o | output | 1 | Check-mode verdict |

## Verification
The hardest case to reach is a true residue match with a non-zero output XOR and reflection on. That only happens when the bench appends the block's own formatted output in exact wire order: low byte first, each byte least-significant bit first. The bench therefore runs a message through the block, captures crc_o, and feeds the same message back in check mode with those captured bits appended. Priority and gap cases are driven by putting start, valid bits and end into the same cycle and by inserting idle cycles between bits. A behavioural long-division model predicts each result.

// File: rtl/crc_pkg.sv
package crc_pkg;
    typedef enum logic {
        MODE_GEN = 1'b0,
        MODE_CHK = 1'b1
    } crc_mode_e;
endpackage

// File: rtl/crc_lfsr_step.sv
// One serial division step: the incoming bit is combined with the bit
// leaving the top of the register, and that feedback folds in the polynomial.
module crc_lfsr_step #(
    parameter int              WIDTH = 16,
    parameter logic [WIDTH-1:0] POLY = 16'h1021
) (
    input  logic [WIDTH-1:0] rem_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] rem_o
);
    logic feedback;

    always_comb begin
        feedback = rem_i[WIDTH-1] ^ bit_i;
        rem_o    = {rem_i[WIDTH-2:0], 1'b0} ^ (feedback ? POLY : '0);
    end
endmodule

// File: rtl/crc_out_fmt.sv
// Output formatting: optional bit reversal, then XOR, then optional byte reversal.
module crc_out_fmt #(
    parameter int               WIDTH     = 16,
    parameter bit               REFLECT   = 1'b0,
    parameter logic [WIDTH-1:0] XOR_OUT   = '0,
    parameter bit               BYTE_SWAP = 1'b0
) (
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] fmt_o
);
    localparam int NBYTES = WIDTH / 8;
    localparam bit DO_SWAP = BYTE_SWAP && (WIDTH % 8 == 0) && (NBYTES > 1);

    logic [WIDTH-1:0] refl;
    logic [WIDTH-1:0] xored;

    generate
        if (REFLECT) begin : g_refl
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                assign refl[i] = raw_i[WIDTH-1-i];
            end
        end else begin : g_norefl
            assign refl = raw_i;
        end
    endgenerate

    assign xored = refl ^ XOR_OUT;

    generate
        if (DO_SWAP) begin : g_swap
            for (genvar k = 0; k < NBYTES; k++) begin : g_byte
                assign fmt_o[8*k +: 8] = xored[8*(NBYTES-1-k) +: 8];
            end
        end else begin : g_noswap
            assign fmt_o = xored;
        end
    endgenerate
endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
    import crc_pkg::*;
#(
    parameter int               WIDTH     = 16,
    parameter logic [WIDTH-1:0] POLY      = 16'h1021,
    parameter logic [WIDTH-1:0] INIT      = '1,
    parameter logic [WIDTH-1:0] XOR_OUT   = '0,
    parameter bit               REFLECT   = 1'b0,
    parameter bit               BYTE_SWAP = 1'b0,
    parameter logic [WIDTH-1:0] RESIDUE   = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             check_i,
    input  logic             bit_valid_i,
    input  logic             bit_i,
    input  logic             end_i,
    output logic [WIDTH-1:0] crc_o,
    output logic             done_o,
    output logic             pass_o
);
    typedef struct packed {
        logic [WIDTH-1:0] rem;
        logic             busy;
        crc_mode_e        mode;
        logic             done;
        logic [WIDTH-1:0] res;
        logic             pass;
    } eng_st_t;

    eng_st_t st_d, st_q;

    logic [WIDTH-1:0] rem_step;
    logic [WIDTH-1:0] rem_final;
    logic [WIDTH-1:0] fmt_final;

    crc_lfsr_step #(
        .WIDTH (WIDTH),
        .POLY  (POLY)
    ) u_step (
        .rem_i (st_q.rem),
        .bit_i (bit_i),
        .rem_o (rem_step)
    );

    // A valid bit in the closing cycle still belongs to the message.
    assign rem_final = bit_valid_i ? rem_step : st_q.rem;

    crc_out_fmt #(
        .WIDTH     (WIDTH),
        .REFLECT   (REFLECT),
        .XOR_OUT   (XOR_OUT),
        .BYTE_SWAP (BYTE_SWAP)
    ) u_fmt (
        .raw_i (rem_final),
        .fmt_o (fmt_final)
    );

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.rem  = INIT;
            st_d.busy = 1'b1;
            st_d.mode = check_i ? MODE_CHK : MODE_GEN;
            st_d.done = 1'b0;
            st_d.pass = 1'b0;
        end else if (st_q.busy) begin
            if (bit_valid_i) begin
                st_d.rem = rem_step;
            end
            if (end_i) begin
                st_d.rem  = rem_final;
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.res  = fmt_final;
                st_d.pass = (st_q.mode == MODE_CHK) && (rem_final == RESIDUE);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign crc_o  = st_q.res;
    assign done_o = st_q.done;
    assign pass_o = st_q.pass;

    // R3: start loads the initial value
    a_r3_init_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (st_q.rem == INIT));

    // R6: start withdraws any previous result
    a_r6_start_drops_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (!done_o && !pass_o));

    // R7: no valid bit, no movement of the remainder
    a_r7_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.busy && !start_i && !bit_valid_i) |=> $stable(st_q.rem));

    // R8: end strobe on an open message produces a result next cycle
    a_r8_end_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.busy && end_i && !start_i) |=> done_o);

    // R8: result is frozen until the next start
    a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !start_i) |=> (done_o && $stable(crc_o) && $stable(pass_o)));

    // R5: generate mode never reports a pass
    a_r5_gen_no_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && st_q.mode == MODE_GEN) |-> !pass_o);
endmodule

// File: tb/crc_serial_engine_tb_top.sv
module crc_serial_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, chk = 1'b0, vld = 1'b0, din = 1'b0, fin = 1'b0;

    logic [2:0]  crc_a;
    logic [15:0] crc_b;
    logic [31:0] crc_c;
    logic done_a, done_b, done_c, pass_a, pass_b, pass_c;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Small textbook generator x^3+x+1
    crc_serial_engine #(.WIDTH(3), .POLY(3'b011), .INIT(3'b000), .XOR_OUT(3'b000),
        .REFLECT(1'b0), .BYTE_SWAP(1'b0), .RESIDUE(3'b000)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .check_i(chk),
        .bit_valid_i(vld), .bit_i(din), .end_i(fin),
        .crc_o(crc_a), .done_o(done_a), .pass_o(pass_a));

    // 16-bit, all-ones start, byte-swapped output
    crc_serial_engine #(.WIDTH(16), .POLY(16'h1021), .INIT(16'hFFFF), .XOR_OUT(16'h0000),
        .REFLECT(1'b0), .BYTE_SWAP(1'b1), .RESIDUE(16'h0000)) dut_b_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .check_i(chk),
        .bit_valid_i(vld), .bit_i(din), .end_i(fin),
        .crc_o(crc_b), .done_o(done_b), .pass_o(pass_b));

    // 32-bit, reflected, inverted
    crc_serial_engine #(.WIDTH(32), .POLY(32'h04C11DB7), .INIT(32'hFFFFFFFF),
        .XOR_OUT(32'hFFFFFFFF), .REFLECT(1'b1), .BYTE_SWAP(1'b0),
        .RESIDUE(32'hC704DD7B)) dut_c_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .check_i(chk),
        .bit_valid_i(vld), .bit_i(din), .end_i(fin),
        .crc_o(crc_c), .done_o(done_c), .pass_o(pass_c));

    // ---------------- behavioural reference ----------------
    bit        m_busy = 1'b0, m_chk = 1'b0, m_done = 1'b0;
    bit        msg[$];
    logic [31:0] e_crc[3];
    bit          e_pass[3];

    // Long division of the (INIT-prefixed, zero-padded) dividend
    function automatic logic [31:0] ref_raw(int n, logic [31:0] poly,
                                            logic [31:0] init, bit m[$]);
        bit a[$];
        logic [31:0] r = '0;
        int len = m.size();
        a = m;
        for (int i = 0; i < n; i++) a.push_back(1'b0);
        for (int i = 0; i < n; i++) a[i] = a[i] ^ init[n-1-i];
        for (int i = 0; i < len; i++) begin
            if (a[i]) begin
                for (int j = 0; j <= n; j++) begin
                    bit c = (j == 0) ? 1'b1 : poly[n-j];
                    a[i+j] = a[i+j] ^ c;
                end
            end
        end
        for (int k = 0; k < n; k++) r[n-1-k] = a[len+k];
        return r;
    endfunction

    function automatic logic [31:0] ref_fmt(int n, logic [31:0] raw, bit refl,
                                            logic [31:0] xo, bit sw);
        logic [31:0] v = '0;
        logic [31:0] o = '0;
        for (int i = 0; i < n; i++) v[i] = refl ? raw[n-1-i] : raw[i];
        v = v ^ xo;
        if (sw && (n % 8 == 0)) begin
            for (int k = 0; k < n/8; k++) o[8*k +: 8] = v[n-8-8*k +: 8];
        end else begin
            o = v;
        end
        return o;
    endfunction

    task automatic model_close();
        logic [31:0] ra, rb, rc;
        ra = ref_raw(3, 32'h3, 32'h0, msg);
        rb = ref_raw(16, 32'h1021, 32'hFFFF, msg);
        rc = ref_raw(32, 32'h04C11DB7, 32'hFFFFFFFF, msg);
        e_crc[0]  = ref_fmt(3, ra, 1'b0, 32'h0, 1'b0);
        e_crc[1]  = ref_fmt(16, rb, 1'b0, 32'h0, 1'b1);
        e_crc[2]  = ref_fmt(32, rc, 1'b1, 32'hFFFFFFFF, 1'b0);
        e_pass[0] = m_chk && (ra == 32'h0);
        e_pass[1] = m_chk && (rb == 32'h0);
        e_pass[2] = m_chk && (rc == 32'hC704DD7B);
    endtask

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: drive away from the edge, advance the model, compare.
    task automatic cyc(bit s, bit v, bit b, bit e, bit c);
        @(negedge clk);
        start = s; vld = v; din = b; fin = e; chk = c;
        @(posedge clk);
        #1;
        if (s) begin
            m_busy = 1'b1; m_chk = c; m_done = 1'b0; msg.delete();
        end else if (m_busy) begin
            if (v) msg.push_back(b);
            if (e) begin
                model_close();
                m_busy = 1'b0; m_done = 1'b1;
            end
        end
        // R8: done flag and held results each cycle
        check({done_a, done_b, done_c} == {3{m_done}}, "R8 done", {done_a, done_b, done_c},
              {3{m_done}});
        if (m_done) begin
            check(crc_a == e_crc[0][2:0] && pass_a == e_pass[0], "R1 small result",
                  {pass_a, crc_a}, {e_pass[0], e_crc[0][2:0]});
            check(crc_b == e_crc[1][15:0] && pass_b == e_pass[1], "R4 16-bit result",
                  {pass_b, crc_b}, {e_pass[1], e_crc[1][15:0]});
            check(crc_c == e_crc[2] && pass_c == e_pass[2], "R4 32-bit result",
                  crc_c, e_crc[2]);
        end else if (!m_busy || s) begin
            check(!pass_a && !pass_b && !pass_c, "R8 pass low", {pass_a, pass_b, pass_c}, 0);
        end
    endtask

    task automatic idle(); cyc(0, 0, 0, 0, 0); endtask
    task automatic open_msg(bit c); cyc(1, 0, 0, 0, c); endtask
    task automatic close_msg(); cyc(0, 0, 0, 1, 0); endtask
    task automatic send_bit(bit b); cyc(0, 1, b, 0, 0); endtask

    task automatic send_byte(logic [7:0] d, bit lsb_first);
        for (int i = 0; i < 8; i++) send_bit(lsb_first ? d[i] : d[7-i]);
    endtask

    task automatic send_digits(bit lsb_first);
        for (int i = 1; i <= 9; i++) send_byte(8'h30 + 8'(i), lsb_first);
    endtask

    localparam logic [13:0] EX_MSG = 14'b11010011101100;

    task automatic send_example(int flip);
        for (int i = 13; i >= 0; i--) send_bit(EX_MSG[i] ^ (flip == 13 - i));
    endtask

    initial begin
        logic [15:0] keep16;
        logic [31:0] keep32;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(!done_a && !done_b && !done_c, "R9 done", {done_a, done_b, done_c}, 0);
        check(crc_a == 0 && crc_b == 0 && crc_c == 0, "R9 crc", crc_c, 0);
        check(!pass_a && !pass_b && !pass_c, "R9 pass", {pass_a, pass_b, pass_c}, 0);
        rst_n = 1'b1;
        idle();

        // R1: textbook example
        open_msg(0); send_example(-1); close_msg();
        check(crc_a == 3'b100, "R1 example", crc_a, 3'b100);

        // R8: idle bits and end strobes after done are ignored
        cyc(0, 1, 1, 0, 0); cyc(0, 1, 0, 1, 0); idle();
        check(crc_a == 3'b100 && done_a, "R8 ignored when idle", crc_a, 3'b100);

        // R2: 16-bit MSB-first known value, swapped by R4
        open_msg(0); send_digits(0); close_msg();
        check(crc_b == 16'hB129, "R2 16-bit known (swapped)", crc_b, 16'hB129);
        keep16 = {crc_b[7:0], crc_b[15:8]};

        // R5: 16-bit codeword check, good then corrupted
        open_msg(1); send_digits(0); for (int i = 15; i >= 0; i--) send_bit(keep16[i]);
        close_msg();
        check(pass_b == 1'b1, "R5 16-bit good codeword", pass_b, 1);
        open_msg(1); send_digits(0);
        for (int i = 15; i >= 0; i--) send_bit(keep16[i] ^ (i == 3));
        close_msg();
        check(pass_b == 1'b0, "R5 16-bit corrupted codeword", pass_b, 0);

        // R2: 32-bit reflected known value
        open_msg(0); send_digits(1); close_msg();
        check(crc_c == 32'hCBF43926, "R2 32-bit known", crc_c, 32'hCBF43926);
        keep32 = crc_c;

        // R5: 32-bit codeword, check value appended low bit first
        open_msg(1); send_digits(1); for (int i = 0; i < 32; i++) send_bit(keep32[i]);
        close_msg();
        check(pass_c == 1'b1, "R5 32-bit good codeword", pass_c, 1);
        open_msg(1); send_digits(1);
        for (int i = 0; i < 32; i++) send_bit(keep32[i] ^ (i == 20));
        close_msg();
        check(pass_c == 1'b0, "R5 32-bit corrupted codeword", pass_c, 0);

        // R5: small codeword and corruption
        open_msg(1); send_example(-1); send_bit(1); send_bit(0); send_bit(0); close_msg();
        check(pass_a == 1'b1, "R5 small good codeword", pass_a, 1);
        open_msg(1); send_example(5); send_bit(1); send_bit(0); send_bit(0); close_msg();
        check(pass_a == 1'b0, "R5 small corrupted codeword", pass_a, 0);

        // R7: gaps between bits, and a bit carried with the end strobe
        open_msg(0);
        for (int i = 13; i >= 1; i--) begin
            send_bit(EX_MSG[i]);
            if (i % 3 == 0) begin idle(); idle(); end
        end
        cyc(0, 1, EX_MSG[0], 1, 0);
        check(crc_a == 3'b100, "R7 gaps and end-cycle bit", crc_a, 3'b100);

        // R6: start with a valid bit in the same cycle drops the bit; restart mid-message
        open_msg(0); send_bit(1); send_bit(1);
        cyc(1, 1, 1, 0, 0);
        send_example(-1); close_msg();
        check(crc_a == 3'b100, "R6 start priority and restart", crc_a, 3'b100);
        check(crc_c == e_crc[2], "R6 32-bit after restart", crc_c, e_crc[2]);

        // R3: leading zeros matter with a non-zero start value only
        open_msg(0); send_bit(0); send_example(-1); close_msg();
        check(crc_a == 3'b100, "R3 zero init ignores leading zero", crc_a, 3'b100);
        keep16 = crc_b;
        open_msg(0); send_bit(0); send_bit(0); send_example(-1); close_msg();
        check(crc_b != keep16, "R3 non-zero init sees leading zeros", crc_b, keep16);

        // R10: empty message
        open_msg(0); close_msg();
        check(crc_b == 16'hFFFF, "R10 empty 16-bit", crc_b, 16'hFFFF);
        check(crc_c == 32'h0, "R10 empty 32-bit", crc_c, 0);
        check(crc_a == 3'b000, "R10 empty small", crc_a, 0);

        // R8: start drops done
        open_msg(0);
        check(!done_a && !done_b && !done_c, "R8 start drops done", done_c, 0);
        close_msg();
        idle();

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule